// File: doc/BRIEF.md
# MII/GMII Transmit Front End with Collision Abort

This block takes frame bytes from an upstream source through a valid/ready handshake and drives them to a PHY across a media-independent interface. In 8-bit mode one byte goes out per clock on `phy_txd[7:0]`. In 4-bit mode each byte goes out as two nibbles on `phy_txd[3:0]`, low nibble first. Frame boundaries come from the source's `src_last` flag. Transmit enable is high only while frame data is on the wire, so each frame begins on a rising edge of `phy_txen`.

An error flag from the source marks that byte and every later byte of the same frame as bad on `phy_txer`. In half-duplex mode a collision seen while the frame is on the wire ends the frame. Transmit enable drops on the next clock, and a one-cycle `abort_retry` pulse tells the source to back off and later restart from a new frame start. The backoff timing itself is left to the source. Carrier sense and local transmit activity retrigger a hold counter, and that counter keeps the `act_led` output on for a programmable number of clocks.

The control is a four-state machine with these states:
- `ST_IDLE`: no frame on the wire.
- `ST_FIRST`: the whole byte in 8-bit mode, or the low nibble in 4-bit mode.
- `ST_SECOND`: the high nibble in 4-bit mode.
- `ST_ABORT`: the single abort cycle.

The transitions are:
- IDLE→FIRST on an accepted byte.
- FIRST→SECOND in 4-bit mode.
- FIRST→FIRST or SECOND→FIRST when the next byte of the frame is accepted.
- FIRST→IDLE or SECOND→IDLE after the last byte, or when the source runs dry.
- FIRST→ABORT or SECOND→ABORT on a half-duplex collision.
- ABORT→IDLE always.

Top module: `mac_tx_front`

## Requirements
- R1: After reset, `phy_txen`, `phy_txer`, `abort_retry` and `act_led` are low, `phy_txd` is zero and `src_ready` is high.
- R2: In 8-bit mode (`gmii_mode`=1 when the frame starts), a byte accepted at a clock edge appears on `phy_txd[7:0]` with `phy_txen` high for the following cycle. The bytes of one frame follow back to back, and `phy_txen` falls in the cycle after the last byte.
- R3: In 4-bit mode (`gmii_mode`=0 when the frame starts), each byte appears as two cycles on `phy_txd[3:0]`, bits 3:0 first and then bits 7:4, with `phy_txd[7:4]`=0. `src_ready` is low while the low nibble is on the wire.
- R4: Once a byte accepted with `src_err`=1 is on the wire, `phy_txer` stays high for it and for every later cycle of that frame. `phy_txer` is low for the bytes before it and whenever `phy_txen` is low.
- R5: With `half_duplex`=1, a collision sampled while `phy_txen` is high forces `phy_txen` low in the next cycle and raises `abort_retry` for exactly that one cycle. No byte is accepted while the collision is present, and the block then returns to idle with `src_ready` high.
- R6: `phy_col` has no effect when `half_duplex`=0, and no effect while no frame is on the wire.
- R7: If `src_valid` is low when the next byte of an unfinished frame is due, the frame ends: `phy_txen` falls after the bytes already accepted.
- R8: `act_led` rises in the cycle after `phy_crs` or `phy_txen` is sampled high. It stays high for exactly ACT_HOLD cycles after the last such sample.
- R9: `src_ready` is low while the final byte of a frame is on the wire, so at least one idle cycle separates frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gmii_mode | input | 1 | 1 = 8-bit lane, 0 = 4-bit lane; sampled at frame start |
| half_duplex | input | 1 | 1 enables collision abort |
| src_valid | input | 1 | Source offers a byte |
| src_data | input | 8 | Offered byte |
| src_last | input | 1 | Offered byte ends the frame |
| src_err | input | 1 | Offered byte is bad; poisons the rest of the frame |
| src_ready | output | 1 | Block accepts the offered byte this cycle |
| phy_txen | output | 1 | Transmit enable towards the PHY |
| phy_txd | output | 8 | Transmit data; bits 3:0 only in 4-bit mode |
| phy_txer | output | 1 | Transmit error towards the PHY |
| phy_col | input | 1 | Collision from the PHY |
| phy_crs | input | 1 | Carrier sense from the PHY |
| abort_retry | output | 1 | One-cycle pulse: frame aborted, restart it |
| act_led | output | 1 | Stretched activity indication |

## Verification
The bench builds the block with ACT_HOLD set to 8. This makes the full rise, hold and fall of the activity stretch observable cycle by cycle, instead of waiting for the default hold of over a million clocks. Both lane widths are exercised with the fixed 8-bit byte. Collision timing is probed at the exact cycle after the first byte appears, which is where abort and acceptance interact.

// File: rtl/mtf_pkg.sv
package mtf_pkg;

    localparam int BYTE_W = 8;
    localparam int NIB_W  = BYTE_W / 2;

    // What the wire carries in the current cycle
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,   // nothing on the wire
        ST_FIRST  = 2'd1,   // full byte (8-bit lane) or low nibble (4-bit lane)
        ST_SECOND = 2'd2,   // high nibble (4-bit lane only)
        ST_ABORT  = 2'd3    // single cycle after a collision
    } tx_state_e;

endpackage

// File: rtl/mtf_ctrl.sv
module mtf_ctrl
    import mtf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      gmii_mode,
    input  logic      half_duplex,
    input  logic      col,
    input  logic      src_valid,
    input  logic      src_last,
    input  logic      src_err,
    output logic      src_ready,
    output logic      load,
    output tx_state_e state,
    output logic      wide_q,
    output logic      tx_en,
    output logic      tx_err,
    output logic      abort_pulse
);

    tx_state_e state_nx;
    logic      last_q;
    logic      err_q;
    logic      col_hit;

    assign col_hit = half_duplex && col;

    // Ready depends on the current state and on a live collision
    always_comb begin
        unique case (state)
            ST_IDLE:   src_ready = 1'b1;
            ST_FIRST:  src_ready = wide_q && !last_q && !col_hit;
            ST_SECOND: src_ready = !last_q && !col_hit;
            ST_ABORT:  src_ready = 1'b0;
            default:   src_ready = 1'b0;
        endcase
    end

    assign load = src_valid && src_ready;

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (load) state_nx = ST_FIRST;
            end
            ST_FIRST: begin
                if (col_hit)      state_nx = ST_ABORT;
                else if (!wide_q) state_nx = ST_SECOND;
                else if (last_q)  state_nx = ST_IDLE;
                else if (load)    state_nx = ST_FIRST;
                else              state_nx = ST_IDLE;
            end
            ST_SECOND: begin
                if (col_hit)     state_nx = ST_ABORT;
                else if (last_q) state_nx = ST_IDLE;
                else if (load)   state_nx = ST_FIRST;
                else             state_nx = ST_IDLE;
            end
            ST_ABORT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register and per-frame flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            last_q <= 1'b0;
            err_q  <= 1'b0;
            wide_q <= 1'b1;
        end else begin
            state <= state_nx;
            if (load) begin
                last_q <= src_last;
                if (state == ST_IDLE) begin
                    wide_q <= gmii_mode;
                    err_q  <= src_err;
                end else begin
                    err_q  <= err_q | src_err;
                end
            end
        end
    end

    // Wire-side outputs, decoded from the state register
    always_comb begin
        tx_en       = 1'b0;
        abort_pulse = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_FIRST:  tx_en = 1'b1;
            ST_SECOND: tx_en = 1'b1;
            ST_ABORT:  abort_pulse = 1'b1;
            default:   ;
        endcase
        tx_err = tx_en && err_q;
    end

    // R5: a half-duplex collision on the wire ends the frame next cycle
    assert_col_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_hit && tx_en) |=> (!tx_en && abort_pulse));

    // R5: the abort indication lasts a single cycle
    assert_abort_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);

    // R4: once bad, the rest of the frame stays bad
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && tx_err) |=> (!tx_en || tx_err));

    // R3: a byte taken for the 4-bit lane blocks the next cycle
    assert_nibble_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && ((state == ST_IDLE) ? !gmii_mode : !wide_q)) |=> !src_ready);

    // R9: the last byte on the wire is never followed by a new acceptance
    assert_frame_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && src_last && gmii_mode && state == ST_IDLE) |=> !src_ready);

endmodule

// File: rtl/mtf_lane.sv
module mtf_lane
    import mtf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] data_in,
    input  tx_state_e         state,
    input  logic              wide,
    output logic [BYTE_W-1:0] txd
);

    logic [BYTE_W-1:0] byte_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byte_q <= '0;
        else if (load) byte_q <= data_in;
    end

    always_comb begin
        unique case (state)
            ST_FIRST:  txd = wide ? byte_q
                                  : {{(BYTE_W-NIB_W){1'b0}}, byte_q[NIB_W-1:0]};
            ST_SECOND: txd = {{(BYTE_W-NIB_W){1'b0}}, byte_q[BYTE_W-1:NIB_W]};
            ST_IDLE:   txd = '0;
            ST_ABORT:  txd = '0;
            default:   txd = '0;
        endcase
    end

    // R3: the upper half of the lane is silent while nibbles are sent
    assert_nibble_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SECOND) |-> (txd[BYTE_W-1:NIB_W] == '0));

endmodule

// File: rtl/mtf_activity.sv
module mtf_activity #(
    parameter int ACT_HOLD = 1_250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic crs,
    input  logic tx_en,
    output logic act
);

    logic busy;
    assign busy = crs || tx_en;

    generate
        if (ACT_HOLD <= 1) begin : g_flop
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) act <= 1'b0;
                else        act <= busy;
            end
        end else begin : g_count
            localparam int CW = $clog2(ACT_HOLD + 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          cnt <= '0;
                else if (busy)       cnt <= CW'(ACT_HOLD);
                else if (cnt != '0)  cnt <= cnt - CW'(1);
            end
            assign act = (cnt != '0);
        end
    endgenerate

    // R8: activity is shown the cycle after it is seen
    assert_act_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> act);

endmodule

// File: rtl/mac_tx_front.sv
module mac_tx_front
    import mtf_pkg::*;
#(
    parameter int ACT_HOLD = 1_250_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gmii_mode,
    input  logic              half_duplex,
    input  logic              src_valid,
    input  logic [BYTE_W-1:0] src_data,
    input  logic              src_last,
    input  logic              src_err,
    output logic              src_ready,
    output logic              phy_txen,
    output logic [BYTE_W-1:0] phy_txd,
    output logic              phy_txer,
    input  logic              phy_col,
    input  logic              phy_crs,
    output logic              abort_retry,
    output logic              act_led
);

    tx_state_e state;
    logic      load;
    logic      wide_q;

    mtf_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .gmii_mode   (gmii_mode),
        .half_duplex (half_duplex),
        .col         (phy_col),
        .src_valid   (src_valid),
        .src_last    (src_last),
        .src_err     (src_err),
        .src_ready   (src_ready),
        .load        (load),
        .state       (state),
        .wide_q      (wide_q),
        .tx_en       (phy_txen),
        .tx_err      (phy_txer),
        .abort_pulse (abort_retry)
    );

    mtf_lane u_lane (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .data_in (src_data),
        .state   (state),
        .wide    (wide_q),
        .txd     (phy_txd)
    );

    mtf_activity #(.ACT_HOLD(ACT_HOLD)) u_act (
        .clk   (clk),
        .rst_n (rst_n),
        .crs   (phy_crs),
        .tx_en (phy_txen),
        .act   (act_led)
    );

    // R6: with full duplex no abort is ever reported
    assert_fd_no_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_duplex && !abort_retry) |=> !abort_retry);

endmodule

// File: tb/mac_tx_front_test.sv
module mac_tx_front_test;

    localparam int HOLD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gmii_mode = 1'b1;
    logic       half_duplex = 1'b0;
    logic       src_valid = 1'b0;
    logic [7:0] src_data = '0;
    logic       src_last = 1'b0;
    logic       src_err = 1'b0;
    logic       src_ready;
    logic       phy_txen;
    logic [7:0] phy_txd;
    logic       phy_txer;
    logic       phy_col = 1'b0;
    logic       phy_crs = 1'b0;
    logic       abort_retry;
    logic       act_led;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    mac_tx_front #(.ACT_HOLD(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .gmii_mode(gmii_mode), .half_duplex(half_duplex),
        .src_valid(src_valid), .src_data(src_data), .src_last(src_last),
        .src_err(src_err), .src_ready(src_ready), .phy_txen(phy_txen),
        .phy_txd(phy_txd), .phy_txer(phy_txer), .phy_col(phy_col),
        .phy_crs(phy_crs), .abort_retry(abort_retry), .act_led(act_led)
    );

    // Wire monitor
    logic [7:0] cap_d [64];
    logic       cap_r [64];
    int  cap_n = 0;
    int  rises = 0;
    int  ab_cnt = 0;
    int  idle_er = 0;
    logic prev_en = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (phy_txen) begin
                if (cap_n < 64) begin
                    cap_d[cap_n] = phy_txd;
                    cap_r[cap_n] = phy_txer;
                end
                cap_n++;
            end
            if (phy_txen && !prev_en) rises++;
            if (abort_retry) ab_cnt++;
            if (!phy_txen && phy_txer) idle_er++;
            prev_en = phy_txen;
        end
    end

    task automatic chk(input string req, input int actv, input int expv);
        nchk++;
        if (actv != expv) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
        end
    endtask

    task automatic clear_mon();
        cap_n = 0; rises = 0; ab_cnt = 0; idle_er = 0;
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    // Offer one byte and wait until it is taken
    task automatic push(input logic [7:0] d, input logic l, input logic e);
        src_valid = 1'b1; src_data = d; src_last = l; src_err = e;
        while (!src_ready) tick();
        tick();
        src_valid = 1'b0; src_last = 1'b0; src_err = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 txen", int'(phy_txen), 0);
        chk("R1 txer", int'(phy_txer), 0);
        chk("R1 abort", int'(abort_retry), 0);
        chk("R1 act", int'(act_led), 0);
        chk("R1 txd", int'(phy_txd), 0);
        chk("R1 ready", int'(src_ready), 1);
    endtask

    task automatic t_wide_frame();
        clear_mon(); gmii_mode = 1'b1;
        push(8'h11, 0, 0); push(8'h22, 0, 0); push(8'h33, 0, 0);
        push(8'h44, 1, 0);
        chk("R9 ready low on last byte", int'(src_ready), 0);
        repeat (4) tick();
        chk("R2 byte count", cap_n, 4);
        chk("R2 one enable rise", rises, 1);
        for (int i = 0; i < 4; i++)
            chk("R2 byte value", int'(cap_d[i]), 17 * (i + 1));
        chk("R2 no txer", int'(cap_r[0] | cap_r[3]), 0);
    endtask

    task automatic t_nibble_frame();
        logic [7:0] exp_n [6];
        exp_n = '{8'h5, 8'hA, 8'hC, 8'h3, 8'hE, 8'h7};
        clear_mon(); gmii_mode = 1'b0;
        push(8'hA5, 0, 0);
        chk("R3 ready low on low nibble", int'(src_ready), 0);
        push(8'h3C, 0, 0); push(8'h7E, 1, 0);
        repeat (5) tick();
        chk("R3 nibble count", cap_n, 6);
        chk("R3 one enable rise", rises, 1);
        for (int i = 0; i < 6; i++)
            chk("R3 nibble value", int'(cap_d[i]), int'(exp_n[i]));
        gmii_mode = 1'b1;
    endtask

    task automatic t_wide_error();
        clear_mon(); gmii_mode = 1'b1;
        push(8'h01, 0, 0); push(8'h02, 0, 1); push(8'h03, 0, 0);
        push(8'h04, 0, 0); push(8'h05, 1, 0);
        repeat (4) tick();
        chk("R4 byte count", cap_n, 5);
        for (int i = 0; i < 5; i++)
            chk("R4 txer per byte", int'(cap_r[i]), (i >= 1) ? 1 : 0);
        chk("R4 txer low when idle", idle_er, 0);
        chk("R4 txer after frame", int'(phy_txer), 0);
    endtask

    task automatic t_nibble_error();
        clear_mon(); gmii_mode = 1'b0;
        push(8'h12, 0, 0); push(8'h34, 1, 1);
        repeat (5) tick();
        chk("R4 nibble count", cap_n, 4);
        for (int i = 0; i < 4; i++)
            chk("R4 nibble txer", int'(cap_r[i]), (i >= 2) ? 1 : 0);
        gmii_mode = 1'b1;
    endtask

    task automatic t_collision();
        clear_mon(); gmii_mode = 1'b1; half_duplex = 1'b1;
        src_valid = 1'b1; src_data = 8'h55; src_last = 1'b0;
        tick();
        chk("R5 txen before collision", int'(phy_txen), 1);
        phy_col = 1'b1; #1;
        chk("R5 ready low under collision", int'(src_ready), 0);
        tick();
        chk("R5 txen dropped", int'(phy_txen), 0);
        chk("R5 abort raised", int'(abort_retry), 1);
        phy_col = 1'b0; src_valid = 1'b0;
        tick();
        chk("R5 abort single cycle", int'(abort_retry), 0);
        chk("R5 ready after abort", int'(src_ready), 1);
        chk("R5 abort count", ab_cnt, 1);
        chk("R5 bytes on wire", cap_n, 1);
        half_duplex = 1'b0;
    endtask

    task automatic t_full_duplex_col();
        clear_mon(); gmii_mode = 1'b1; half_duplex = 1'b0; phy_col = 1'b1;
        push(8'hA1, 0, 0); push(8'hA2, 0, 0); push(8'hA3, 0, 0);
        push(8'hA4, 1, 0);
        repeat (4) tick();
        phy_col = 1'b0;
        chk("R6 full duplex frame intact", cap_n, 4);
        chk("R6 full duplex last byte", int'(cap_d[3]), 8'hA4);
        chk("R6 full duplex no abort", ab_cnt, 0);
    endtask

    task automatic t_idle_col();
        clear_mon(); half_duplex = 1'b1; phy_col = 1'b1;
        repeat (5) tick();
        chk("R6 idle collision no abort", ab_cnt, 0);
        chk("R6 idle collision ready", int'(src_ready), 1);
        phy_col = 1'b0; half_duplex = 1'b0;
    endtask

    task automatic t_underrun();
        clear_mon(); gmii_mode = 1'b1;
        push(8'h6B, 0, 0);
        repeat (4) tick();
        chk("R7 underrun length", cap_n, 1);
        chk("R7 underrun byte", int'(cap_d[0]), 8'h6B);
        chk("R7 txen low", int'(phy_txen), 0);
    endtask

    task automatic t_activity();
        repeat (HOLD + 4) tick();
        chk("R8 act idle", int'(act_led), 0);
        phy_crs = 1'b1;
        tick();
        phy_crs = 1'b0;
        chk("R8 act on", int'(act_led), 1);
        for (int k = 1; k < HOLD; k++) begin
            tick();
            chk("R8 act held", int'(act_led), 1);
        end
        tick();
        chk("R8 act released", int'(act_led), 0);
    endtask

    initial begin
        #(8 * 150000);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_wide_frame();
        t_nibble_frame();
        t_wide_error();
        t_nibble_error();
        t_collision();
        t_full_duplex_col();
        t_idle_col();
        t_underrun();
        t_activity();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule